// File: doc/BRIEF.md
# Bit and Shift Group Execution Unit

This unit carries out one instruction from the second-page rotate, shift and single-bit group on an 8-bit operand. The surrounding core fetches the operand, either from a register or from a memory byte, and presents it with the final opcode byte, the current flag byte and a flag that says whether the instruction came through the indexed-memory path. One clock after `start`, the unit returns the result byte and the new flag byte. It also returns write-back strobes that tell the core where the result goes: a register (and which one), memory, or both.

In the indexed form, the operation always works on the memory byte and the result is always written back to memory. When the opcode's operand field names a register instead of memory, the result is also copied into that register, provided `INDEX_COPY` is 1. With `INDEX_COPY` set to 0, the indexed form writes memory only. Operand fetch and memory timing belong to the core.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `regWrEn` and `memWrEn` are 0, and `result` and `flagsOut` are 0 until the first operation.
- R2: A `start` pulse in one cycle gives `done` = 1 in the next cycle only. `result`, `flagsOut` and `regSel` hold their values until the next `start`. `regWrEn` and `memWrEn` are high only while `done` is high.
- R3: Opcode bits 2:0 name the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory, 7=A. In the plain form (`indexed`=0), code 6 gives `memWrEn` and no register write. Any other code gives `regWrEn` with `regSel` equal to that code.
- R4: For opcodes 00–3F, bits 5:3 pick the operation. 0 rotates left circularly and 1 rotates right circularly. 2 rotates left through carry and 3 rotates right through carry. 4 shifts left arithmetically with a 0 in. 5 shifts right and keeps bit 7. 6 shifts left with bit 0 forced to 1. 7 shifts right with a 0 into bit 7. The bit that leaves goes to carry.
- R5: The flag byte layout is S=bit 7, Z=6, H=4, P/V=2, N=1, C=0. Bits 5 and 3 pass through from `flagsIn`. For a rotate or shift, S is result bit 7, Z is 1 when the result is zero, P/V is 1 when the result holds an even number of ones, H and N are 0, and C is the bit shifted out.
- R6: For opcodes 40–7F, the unit tests the bit numbered by bits 5:3. Z becomes the inverse of that bit, H becomes 1 and N becomes 0. S, P/V, C and bits 5 and 3 are kept, `result` equals the operand, and no write strobe is raised.
- R7: Opcodes 80–BF clear, and C0–FF set, the bit numbered by bits 5:3. Every other bit of the operand is kept, and `flagsOut` equals `flagsIn`.
- R8: In the indexed form, every non-test opcode raises `memWrEn`. When `INDEX_COPY`=1 and bits 2:0 are not 6, it also raises `regWrEn` with `regSel` equal to bits 2:0.
- R9: An indexed bit test (40–7F) raises neither write strobe.
- R10: With `INDEX_COPY`=0, an indexed operation never raises `regWrEn`, but it still raises `memWrEn` for non-test opcodes. The plain form behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation this cycle |
| opcode | input | 8 | Final opcode byte of the group |
| operand | input | 8 | Operand byte (register or memory value) |
| flagsIn | input | 8 | Current flag byte; bit 0 is the carry-in |
| indexed | input | 1 | 1 when the instruction came through the indexed-memory path |
| done | output | 1 | Result valid, one cycle after start |
| result | output | 8 | Result byte |
| flagsOut | output | 8 | Updated flag byte |
| regWrEn | output | 1 | Write result to the register named by regSel |
| regSel | output | 3 | Destination register code (bits 2:0 of the opcode) |
| memWrEn | output | 1 | Write result back to the memory byte |

## Verification
A wrong decode of the opcode class shows up in the same `done` cycle in two ways. A bit test starts to raise write strobes, or a set or reset operation disturbs the flag byte. A wrong operand-field decode shows as a write strobe aimed at the wrong side, register versus memory. A broken shift selection, or a dropped carry-in, corrupts `result` or C on the very next cycle after `start`. The table therefore holds at least one vector per shift kind, chosen so that the carry-out and the parity differ from the neighbouring kinds. Because the outputs are registered and then held, a load strobe that fires when it should not shows up as a changed `result` after a cycle without `start`.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  // flag byte bit positions
  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_H  = 4;
  localparam int F_PV = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;
  localparam logic [SEL_W-1:0] MEM_CODE = 3'd6;

  typedef enum logic [1:0] {
    K_SHIFT = 2'd0,
    K_TEST  = 2'd1,
    K_RES   = 2'd2,
    K_SET   = 2'd3
  } op_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    op_kind_e         kind;
    logic [SEL_W-1:0] shiftSel;
    logic [SEL_W-1:0] bitIdx;
  } dp_ctl_t;
endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter bit INDEX_COPY = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic             indexed,
  output dp_ctl_t          ctl,
  output logic             done,
  output logic             regWrEn,
  output logic [SEL_W-1:0] regSel,
  output logic             memWrEn
);
  op_kind_e kindNow;
  logic     isMemSel;
  logic     wantMem;
  logic     wantReg;
  logic     testQ;

  always_comb begin
    kindNow  = op_kind_e'(opcode[7:6]);
    isMemSel = (opcode[2:0] == MEM_CODE);
    wantMem  = (kindNow != K_TEST) && (indexed || isMemSel);
    wantReg  = (kindNow != K_TEST) && !isMemSel && (!indexed || INDEX_COPY);
    ctl.load     = start;
    ctl.kind     = kindNow;
    ctl.shiftSel = opcode[5:3];
    ctl.bitIdx   = opcode[5:3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      regWrEn <= 1'b0;
      memWrEn <= 1'b0;
      regSel  <= '0;
      testQ   <= 1'b0;
    end else begin
      done    <= start;
      regWrEn <= start && wantReg;
      memWrEn <= start && wantMem;
      testQ   <= start && (kindNow == K_TEST);
      if (start) regSel <= opcode[2:0];
    end
  end

  // R2: done follows start by exactly one cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
  a_r2_strobe_in_done: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || memWrEn) |-> done);
  // R9 / R6: a bit test never writes back
  a_r9_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    testQ |-> !(regWrEn || memWrEn));
  // R8: indexed non-test always writes memory
  a_r8_idx_mem: assert property (@(posedge clk) disable iff (!rstN)
    (start && indexed && opcode[7:6] != 2'b01) |=> memWrEn);
  // R10: memory-only indexed variant never copies into a register
  a_r10_no_copy: assert property (@(posedge clk) disable iff (!rstN)
    (start && indexed && !INDEX_COPY) |=> !regWrEn);
endmodule

// File: rtl/bitop_dp.sv
module bitop_dp
  import bitop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shRes;
  logic              shOut;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] nextRes;
  logic [DATA_W-1:0] nextFlags;
  logic              cIn;

  always_comb begin
    cIn = flagsIn[F_C];
    unique case (ctl.shiftSel)
      3'd0: begin shRes = {operand[MSB-1:0], operand[MSB]}; shOut = operand[MSB]; end
      3'd1: begin shRes = {operand[0], operand[MSB:1]};     shOut = operand[0];   end
      3'd2: begin shRes = {operand[MSB-1:0], cIn};          shOut = operand[MSB]; end
      3'd3: begin shRes = {cIn, operand[MSB:1]};            shOut = operand[0];   end
      3'd4: begin shRes = {operand[MSB-1:0], 1'b0};         shOut = operand[MSB]; end
      3'd5: begin shRes = {operand[MSB], operand[MSB:1]};   shOut = operand[0];   end
      3'd6: begin shRes = {operand[MSB-1:0], 1'b1};         shOut = operand[MSB]; end
      default: begin shRes = {1'b0, operand[MSB:1]};        shOut = operand[0];   end
    endcase

    bitMask   = DATA_W'(1) << ctl.bitIdx;
    nextFlags = flagsIn;
    unique case (ctl.kind)
      K_SHIFT: begin
        nextRes          = shRes;
        nextFlags[F_S]   = shRes[MSB];
        nextFlags[F_Z]   = (shRes == '0);
        nextFlags[F_H]   = 1'b0;
        nextFlags[F_PV]  = ~^shRes;
        nextFlags[F_N]   = 1'b0;
        nextFlags[F_C]   = shOut;
      end
      K_TEST: begin
        nextRes          = operand;
        nextFlags[F_Z]   = ((operand & bitMask) == '0);
        nextFlags[F_H]   = 1'b1;
        nextFlags[F_N]   = 1'b0;
      end
      K_RES:   nextRes = operand & ~bitMask;
      default: nextRes = operand | bitMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      flagsOut <= '0;
    end else if (ctl.load) begin
      result   <= nextRes;
      flagsOut <= nextFlags;
    end
  end

  // R7: set/reset leave flags untouched
  a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && (ctl.kind == K_RES || ctl.kind == K_SET)) |=> flagsOut == $past(flagsIn));
  // R6: bit test keeps carry, sets H, clears N, passes operand
  a_r6_test_flags: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.kind == K_TEST) |=>
      (flagsOut[F_C] == $past(flagsIn[F_C])) && flagsOut[F_H] && !flagsOut[F_N]
      && result == $past(operand));
  // R5: shifts clear H and N
  a_r5_hn_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.kind == K_SHIFT) |=> !flagsOut[F_H] && !flagsOut[F_N]);
  // R2: outputs hold without a load
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(result) && $stable(flagsOut));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter bit INDEX_COPY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic              indexed,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsOut,
  output logic              regWrEn,
  output logic [SEL_W-1:0]  regSel,
  output logic              memWrEn
);
  dp_ctl_t ctl;

  bitop_ctrl #(.INDEX_COPY(INDEX_COPY)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .indexed(indexed),
    .ctl(ctl), .done(done), .regWrEn(regWrEn), .regSel(regSel), .memWrEn(memWrEn)
  );

  bitop_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut)
  );
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = '0;
  logic [7:0] operand = '0;
  logic [7:0] flagsIn = '0;
  logic       indexed = 1'b0;
  logic       done, regWrEn, memWrEn;
  logic [7:0] result, flagsOut;
  logic [2:0] regSel;
  logic       aDone, aRegWr, aMemWr;
  logic [7:0] aResult, aFlags;
  logic [2:0] aRegSel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bitop_unit #(.INDEX_COPY(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .flagsIn(flagsIn), .indexed(indexed), .done(done), .result(result),
    .flagsOut(flagsOut), .regWrEn(regWrEn), .regSel(regSel), .memWrEn(memWrEn)
  );

  bitop_unit #(.INDEX_COPY(1'b0)) dut_alt_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .flagsIn(flagsIn), .indexed(indexed), .done(aDone), .result(aResult),
    .flagsOut(aFlags), .regWrEn(aRegWr), .regSel(aRegSel), .memWrEn(aMemWr)
  );

  // {indexed, opcode, operand, flagsIn, expResult, expFlags, expReg, expMem, reqNo}
  localparam int NV = 16;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h85, 8'h00, 8'h0B, 8'h01, 1'b1, 1'b0, 4'd4}, // R4 rotate left circ
    {1'b0, 8'h09, 8'h01, 8'h00, 8'h80, 8'h81, 1'b1, 1'b0, 4'd4}, // R4 rotate right circ
    {1'b0, 8'h12, 8'h80, 8'h00, 8'h00, 8'h45, 1'b1, 1'b0, 4'd5}, // R5 zero + parity
    {1'b0, 8'h1B, 8'h02, 8'h01, 8'h81, 8'h84, 1'b1, 1'b0, 4'd4}, // R4 through carry
    {1'b0, 8'h24, 8'hC1, 8'h01, 8'h82, 8'h85, 1'b1, 1'b0, 4'd4}, // R4 arith left
    {1'b0, 8'h2D, 8'h81, 8'h00, 8'hC0, 8'h85, 1'b1, 1'b0, 4'd4}, // R4 keep sign
    {1'b0, 8'h36, 8'h80, 8'h00, 8'h01, 8'h01, 1'b0, 1'b1, 4'd3}, // R3 mem dest, shift-left-set
    {1'b0, 8'h3F, 8'h01, 8'h28, 8'h00, 8'h6D, 1'b1, 1'b0, 4'd5}, // R5 pass bits 5,3
    {1'b0, 8'h5F, 8'hF7, 8'h81, 8'hF7, 8'hD1, 1'b0, 1'b0, 4'd6}, // R6 tested bit 0
    {1'b0, 8'h78, 8'h80, 8'h43, 8'h80, 8'h11, 1'b0, 1'b0, 4'd6}, // R6 tested bit 1
    {1'b0, 8'hA9, 8'hFF, 8'hA5, 8'hDF, 8'hA5, 1'b1, 1'b0, 4'd7}, // R7 clear bit 5
    {1'b0, 8'hC6, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, 4'd7}, // R7 set bit 0 mem
    {1'b1, 8'h00, 8'h85, 8'h00, 8'h0B, 8'h01, 1'b1, 1'b1, 4'd8}, // R8 copy to reg
    {1'b1, 8'hFE, 8'h00, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1, 4'd8}, // R8 mem only
    {1'b1, 8'h53, 8'h04, 8'h00, 8'h04, 8'h10, 1'b0, 1'b0, 4'd9}, // R9 indexed test
    {1'b1, 8'h87, 8'hFF, 8'h00, 8'hFE, 8'h00, 1'b1, 1'b1, 4'd8}  // R8 copy to A
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic idx, input logic [7:0] op,
                       input logic [7:0] val, input logic [7:0] fin);
    @(negedge clk);
    indexed = idx; opcode = op; operand = val; flagsIn = fin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !regWrEn && !memWrEn && result == 8'h00 && flagsOut == 8'h00,
          "R1", "reset outputs", {done, regWrEn, memWrEn, result, flagsOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !regWrEn && !memWrEn && result == 8'h00, "R1", "after release",
          {done, regWrEn, memWrEn, result}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        vIdx;
      logic [7:0]  vOp, vVal, vFin, eRes, eFl;
      logic        eReg, eMem;
      logic [3:0]  rq;
      string       tag;
      {vIdx, vOp, vVal, vFin, eRes, eFl, eReg, eMem, rq} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      runOp(vIdx, vOp, vVal, vFin);
      check(done, tag, "done", {31'h0, done}, 32'h1);
      check(result == eRes, tag, "result", {24'h0, result}, {24'h0, eRes});
      check(flagsOut == eFl, tag, "flags", {24'h0, flagsOut}, {24'h0, eFl});
      check(regWrEn == eReg && memWrEn == eMem, tag, "strobes",
            {30'h0, regWrEn, memWrEn}, {30'h0, eReg, eMem});
      if (eReg)
        check(regSel == vOp[2:0], tag, "regSel", {29'h0, regSel}, {29'h0, vOp[2:0]});
      // R10: alternative variant never copies on the indexed path
      check(aRegWr == (eReg && !vIdx) && aMemWr == eMem, "R10", "alt strobes",
            {30'h0, aRegWr, aMemWr}, {30'h0, eReg && !vIdx, eMem});
    end

    // R2: done is a single pulse, outputs hold, strobes drop
    runOp(1'b0, 8'h06, 8'h40, 8'h00);  // rotate left circ of memory: 0x80
    check(done && result == 8'h80, "R2", "first cycle", {23'h0, done, result}, {23'h0, 1'b1, 8'h80});
    @(negedge clk);
    check(!done && !memWrEn && !regWrEn, "R2", "done single cycle",
          {29'h0, done, memWrEn, regWrEn}, 32'h0);
    operand = 8'h33; opcode = 8'hFF;
    @(negedge clk);
    check(result == 8'h80 && flagsOut == 8'h80, "R2", "held outputs",
          {16'h0, result, flagsOut}, {16'h0, 8'h80, 8'h80});

    // R3: every plain register code targets its own register
    for (int r = 0; r < 8; r++) begin
      runOp(1'b0, 8'hC0 | 8'(r), 8'h00, 8'h00);
      if (r == 6)
        check(memWrEn && !regWrEn, "R3", "mem code",
              {30'h0, regWrEn, memWrEn}, 32'h1);
      else
        check(regWrEn && !memWrEn && regSel == 3'(r), "R3", "reg code",
              {27'h0, regWrEn, memWrEn, regSel}, {27'h0, 1'b1, 1'b0, 3'(r)});
    end

    // R4: shift-left-set on all-ones keeps bit 0 set and carries out
    runOp(1'b0, 8'h37, 8'hFF, 8'h00);
    check(result == 8'hFF && flagsOut == 8'h85, "R4", "shift-left-set ones",
          {16'h0, result, flagsOut}, {16'h0, 8'hFF, 8'h85});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule